// File: doc/BRIEF.md
# Mode-Controller Interrupt Status and Mask Registers

This block collects four events from a power/mode management controller into sticky status flags and combines them into a single interrupt request. The events are a rejected write of an illegal mode configuration, a request for an illegal mode change, an entry into the safe mode forced by hardware, and the end of a mode transition. A mode transition is reported through a busy level together with the code of the mode being entered.

Software reaches two 16-bit registers over a simple single-cycle register bus. The status register is cleared by writing ones. The mask register holds one enable bit per status flag. Only accesses at supervisor (or test) privilege can change either register. The interrupt output is registered and asserts while any enabled flag is set.

Top module: `mode_irq_regs`

## Requirements
- R1: After synchronous reset (rst_n low at a clock edge), the status register, the mask register and irq are all 0.
- R2: Status flag positions: bit 3 = illegal configuration (ev_bad_cfg), bit 2 = illegal mode request (ev_bad_mode), bit 1 = hardware safe entry, bit 0 = transition done. A flag sets at the clock edge where its event is high and stays set until software clears it.
- R3: A privileged write to the status address (0) clears every flag whose wdata bit is 1. Flags whose wdata bit is 0 keep their value.
- R4: The transition-done flag sets at the edge where xfer_busy is 0 and xfer_busy was 1 at the previous edge. It does not set while xfer_busy stays high or rises.
- R5: The transition-done flag is not set when xfer_target, sampled in the cycle where busy falls, equals the deep-halt code (8) or the deep-stop code (10).
- R6: The safe-entry flag sets only when safe_enter and safe_by_hw are both high. A safe entry with safe_by_hw low leaves the flag unchanged.
- R7: The mask register sits at address 1 and holds wdata[3:0] in the same bit order as status. Bits 15:4 of both registers read as 0, and any other address reads 0.
- R8: irq is a register equal to the OR over the four bits of (status AND mask), one clock after those values. A newly set, enabled flag raises irq one cycle after the flag itself sets.
- R9: A write with bus_priv low changes neither register. Reads succeed at either privilege.
- R10: When a hardware set event and a write-1-clear hit the same flag in the same cycle, the flag ends up set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ev_bad_cfg | input | 1 | Rejected illegal mode-configuration write event |
| ev_bad_mode | input | 1 | Illegal mode-change request event |
| safe_enter | input | 1 | Safe mode being entered this cycle |
| safe_by_hw | input | 1 | Safe entry caused by a hardware request |
| xfer_busy | input | 1 | Mode transition in progress |
| xfer_target | input | MODE_W (4) | Code of the mode being entered |
| bus_sel | input | 1 | Bus access strobe |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_priv | input | 1 | 1 = supervisor/test, 0 = user |
| bus_addr | input | ADDR_W (4) | Register word address |
| bus_wdata | input | DATA_W (16) | Write data |
| bus_rdata | output | DATA_W (16) | Read data, valid in the cycle of a read |
| irq | output | 1 | Combined interrupt request |

## Verification
The bench builds the block with its default parameters: a 4-bit mode code, a 4-bit address and a 16-bit data view. With these values every target mode code, every write-1-clear pattern and every pairing of status and mask values can be swept in full. All 16 transition targets are driven through a falling busy edge, all 16 clear patterns are applied to a fully set status register, and all 256 status/mask combinations are compared against the arithmetic OR of their AND. Directed sequences cover the one-cycle interrupt latency, user-privilege writes, the safe-entry cause, and a set colliding with a clear.

// File: rtl/mode_irq_pkg.sv
// Package: mode_irq_pkg
// Shared constants for the mode-controller interrupt register block.
// Assumes the bit positions below are decoded by software, so they are fixed.
package mode_irq_pkg;
    localparam int NUM_SRC  = 4;
    localparam int IDX_DONE = 0;
    localparam int IDX_SAFE = 1;
    localparam int IDX_MODE = 2;
    localparam int IDX_CFG  = 3;
endpackage

// File: rtl/mode_irq_xfer_det.sv
// Module: mode_irq_xfer_det
// Detects the end of a mode transition (busy falling) and qualifies it by the
// target mode code present in that same cycle. Ends into either deep
// low-power mode produce no event.
// Assumes xfer_busy is synchronous to clk.
module mode_irq_xfer_det #(
    parameter int                 MODE_W  = 4,
    parameter logic [MODE_W-1:0]  LP_HALT = MODE_W'(8),
    parameter logic [MODE_W-1:0]  LP_STOP = MODE_W'(10)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              busy,
    input  logic [MODE_W-1:0] target,
    output logic              done_set
);
    logic busy_q;
    logic deep_lp;

    // Keep last cycle's busy level for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) busy_q <= 1'b0;
        else        busy_q <= busy;
    end

    // Flag targets that must not report completion.
    always_comb begin
        deep_lp = (target == LP_HALT) || (target == LP_STOP);
    end

    // Completion event: busy fell and the target is not a deep low-power mode.
    always_comb begin
        done_set = busy_q && !busy && !deep_lp;
    end
endmodule

// File: rtl/mode_irq_flag.sv
// Module: mode_irq_flag
// One sticky status bit: set by hardware, cleared by software, set has priority.
// Assumes set and clr are single-cycle qualified strobes.
module mode_irq_flag (
    input  logic clk,
    input  logic rst_n,
    input  logic set,
    input  logic clr,
    output logic q
);
    // Sticky bit update; a same-cycle set overrides the clear.
    always_ff @(posedge clk) begin
        if (!rst_n)   q <= 1'b0;
        else if (set) q <= 1'b1;
        else if (clr) q <= 1'b0;
    end
endmodule

// File: rtl/mode_irq_bus.sv
// Module: mode_irq_bus
// Decodes the register bus: privilege-checked writes produce clear strobes for
// the status bits and a load strobe for the mask; reads return the addressed
// register zero-extended. Assumes single-cycle accesses, no wait states.
module mode_irq_bus #(
    parameter int                 ADDR_W    = 4,
    parameter int                 DATA_W    = 16,
    parameter int                 NUM_SRC   = 4,
    parameter logic [ADDR_W-1:0]  STAT_ADDR = ADDR_W'(0),
    parameter logic [ADDR_W-1:0]  MASK_ADDR = ADDR_W'(1)
) (
    input  logic               bus_sel,
    input  logic               bus_wr,
    input  logic               bus_priv,
    input  logic [ADDR_W-1:0]  bus_addr,
    input  logic [DATA_W-1:0]  bus_wdata,
    input  logic [NUM_SRC-1:0] status,
    input  logic [NUM_SRC-1:0] mask,
    output logic [NUM_SRC-1:0] clr_vec,
    output logic               mask_we,
    output logic [NUM_SRC-1:0] mask_wdata,
    output logic [DATA_W-1:0]  rdata
);
    logic wr_ok;

    // Only privileged writes may modify state.
    always_comb begin
        wr_ok = bus_sel && bus_wr && bus_priv;
    end

    // Write-one-to-clear strobes for the status register.
    always_comb begin
        clr_vec = (wr_ok && (bus_addr == STAT_ADDR)) ? bus_wdata[NUM_SRC-1:0] : '0;
    end

    // Mask load strobe and data.
    always_comb begin
        mask_we    = wr_ok && (bus_addr == MASK_ADDR);
        mask_wdata = bus_wdata[NUM_SRC-1:0];
    end

    // Read mux; unused bits and unmapped addresses return zero.
    always_comb begin
        rdata = '0;
        if (bus_sel && !bus_wr) begin
            if (bus_addr == STAT_ADDR)      rdata[NUM_SRC-1:0] = status;
            else if (bus_addr == MASK_ADDR) rdata[NUM_SRC-1:0] = mask;
        end
    end
endmodule

// File: rtl/mode_irq_regs.sv
// Module: mode_irq_regs
// Top of the interrupt status/mask block. Gathers four mode-management events
// into sticky flags, holds a per-flag enable mask and drives one registered
// interrupt request. Assumes all inputs are synchronous to clk.
module mode_irq_regs #(
    parameter int                 ADDR_W    = 4,
    parameter int                 DATA_W    = 16,
    parameter int                 MODE_W    = 4,
    parameter logic [ADDR_W-1:0]  STAT_ADDR = ADDR_W'(0),
    parameter logic [ADDR_W-1:0]  MASK_ADDR = ADDR_W'(1),
    parameter logic [MODE_W-1:0]  LP_HALT   = MODE_W'(8),
    parameter logic [MODE_W-1:0]  LP_STOP   = MODE_W'(10)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ev_bad_cfg,
    input  logic              ev_bad_mode,
    input  logic              safe_enter,
    input  logic              safe_by_hw,
    input  logic              xfer_busy,
    input  logic [MODE_W-1:0] xfer_target,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic              bus_priv,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              irq
);
    localparam int NSRC = mode_irq_pkg::NUM_SRC;

    logic [NSRC-1:0] set_vec;
    logic [NSRC-1:0] clr_vec;
    logic [NSRC-1:0] status_q;
    logic [NSRC-1:0] mask_q;
    logic [NSRC-1:0] mask_wdata;
    logic            mask_we;
    logic            done_set;

    mode_irq_xfer_det #(
        .MODE_W  (MODE_W),
        .LP_HALT (LP_HALT),
        .LP_STOP (LP_STOP)
    ) u_xfer (
        .clk      (clk),
        .rst_n    (rst_n),
        .busy     (xfer_busy),
        .target   (xfer_target),
        .done_set (done_set)
    );

    // Route each event to its fixed status bit position.
    always_comb begin
        set_vec                         = '0;
        set_vec[mode_irq_pkg::IDX_CFG]  = ev_bad_cfg;
        set_vec[mode_irq_pkg::IDX_MODE] = ev_bad_mode;
        set_vec[mode_irq_pkg::IDX_SAFE] = safe_enter && safe_by_hw;
        set_vec[mode_irq_pkg::IDX_DONE] = done_set;
    end

    for (genvar i = 0; i < NSRC; i++) begin : g_flag
        mode_irq_flag u_flag (
            .clk   (clk),
            .rst_n (rst_n),
            .set   (set_vec[i]),
            .clr   (clr_vec[i]),
            .q     (status_q[i])
        );
    end

    mode_irq_bus #(
        .ADDR_W    (ADDR_W),
        .DATA_W    (DATA_W),
        .NUM_SRC   (NSRC),
        .STAT_ADDR (STAT_ADDR),
        .MASK_ADDR (MASK_ADDR)
    ) u_bus (
        .bus_sel    (bus_sel),
        .bus_wr     (bus_wr),
        .bus_priv   (bus_priv),
        .bus_addr   (bus_addr),
        .bus_wdata  (bus_wdata),
        .status     (status_q),
        .mask       (mask_q),
        .clr_vec    (clr_vec),
        .mask_we    (mask_we),
        .mask_wdata (mask_wdata),
        .rdata      (bus_rdata)
    );

    // Mask register, loaded by privileged writes.
    always_ff @(posedge clk) begin
        if (!rst_n)       mask_q <= '0;
        else if (mask_we) mask_q <= mask_wdata;
    end

    // Registered combined interrupt request.
    always_ff @(posedge clk) begin
        if (!rst_n) irq <= 1'b0;
        else        irq <= |(status_q & mask_q);
    end
endmodule

// File: rtl/mode_irq_regs_chk.sv
// Module: mode_irq_regs_chk
// Assertion checker bound to mode_irq_regs. Observes the ports plus the
// status and mask registers, and keeps its own copy of the previous busy level.
module mode_irq_regs_chk #(
    parameter int                 ADDR_W    = 4,
    parameter int                 DATA_W    = 16,
    parameter int                 MODE_W    = 4,
    parameter logic [ADDR_W-1:0]  STAT_ADDR = ADDR_W'(0),
    parameter logic [ADDR_W-1:0]  MASK_ADDR = ADDR_W'(1),
    parameter logic [MODE_W-1:0]  LP_HALT   = MODE_W'(8),
    parameter logic [MODE_W-1:0]  LP_STOP   = MODE_W'(10)
) (
    input logic              clk,
    input logic              rst_n,
    input logic              ev_bad_cfg,
    input logic              ev_bad_mode,
    input logic              safe_enter,
    input logic              safe_by_hw,
    input logic              xfer_busy,
    input logic [MODE_W-1:0] xfer_target,
    input logic              bus_sel,
    input logic              bus_wr,
    input logic              bus_priv,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [DATA_W-1:0] bus_wdata,
    input logic [3:0]        status_q,
    input logic [3:0]        mask_q,
    input logic              irq
);
    logic       prev_busy;
    logic       deep;
    logic       user_wr;
    logic [3:0] wclr;

    // Independent history of the busy level.
    always_ff @(posedge clk) begin
        if (!rst_n) prev_busy <= 1'b0;
        else        prev_busy <= xfer_busy;
    end

    // Decode helpers derived from the ports.
    always_comb begin
        deep    = (xfer_target == LP_HALT) || (xfer_target == LP_STOP);
        user_wr = bus_sel && bus_wr && !bus_priv;
        wclr    = (bus_sel && bus_wr && bus_priv && bus_addr == STAT_ADDR) ? bus_wdata[3:0] : 4'h0;
    end

    AST_RESET_CLEARS: assert property (@(posedge clk)
        !rst_n |=> (status_q == 4'h0 && mask_q == 4'h0 && !irq)); // R1
    AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        ((status_q & ~wclr) != 4'h0) |=> (($past(status_q & ~wclr) & ~status_q) == 4'h0)); // R2
    AST_DONE_ON_FALL: assert property (@(posedge clk) disable iff (!rst_n)
        (prev_busy && !xfer_busy && !deep) |=> status_q[0]); // R4
    AST_DEEP_SUPPRESS: assert property (@(posedge clk) disable iff (!rst_n)
        (prev_busy && !xfer_busy && deep && !status_q[0]) |=> !status_q[0]); // R5
    AST_SAFE_SW_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (safe_enter && !safe_by_hw && !status_q[1]) |=> !status_q[1]); // R6
    AST_IRQ_RAISE: assert property (@(posedge clk) disable iff (!rst_n)
        ((status_q & mask_q) != 4'h0) |=> irq); // R8
    AST_IRQ_DROP: assert property (@(posedge clk) disable iff (!rst_n)
        ((status_q & mask_q) == 4'h0) |=> !irq); // R8
    AST_USER_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        user_wr |=> ($stable(mask_q) && (($past(status_q) & ~status_q) == 4'h0))); // R9
    AST_SET_BEATS_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        (ev_bad_cfg || ev_bad_mode) |=> ((ev_bad_cfg ? status_q[3] : 1'b1) || !$past(ev_bad_cfg))
                                        && (status_q[2] || !$past(ev_bad_mode))); // R10
endmodule

bind mode_irq_regs mode_irq_regs_chk #(
    .ADDR_W    (ADDR_W),
    .DATA_W    (DATA_W),
    .MODE_W    (MODE_W),
    .STAT_ADDR (STAT_ADDR),
    .MASK_ADDR (MASK_ADDR),
    .LP_HALT   (LP_HALT),
    .LP_STOP   (LP_STOP)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .ev_bad_cfg  (ev_bad_cfg),
    .ev_bad_mode (ev_bad_mode),
    .safe_enter  (safe_enter),
    .safe_by_hw  (safe_by_hw),
    .xfer_busy   (xfer_busy),
    .xfer_target (xfer_target),
    .bus_sel     (bus_sel),
    .bus_wr      (bus_wr),
    .bus_priv    (bus_priv),
    .bus_addr    (bus_addr),
    .bus_wdata   (bus_wdata),
    .status_q    (status_q),
    .mask_q      (mask_q),
    .irq         (irq)
);

// File: tb/mode_irq_regs_bench.sv
`timescale 1ns/1ps
// Bench for mode_irq_regs: sweeps clear patterns, target codes and all
// status/mask pairs, with directed checks for privilege, cause and collisions.
module mode_irq_regs_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ev_bad_cfg = 1'b0;
    logic        ev_bad_mode = 1'b0;
    logic        safe_enter = 1'b0;
    logic        safe_by_hw = 1'b0;
    logic        xfer_busy = 1'b0;
    logic [3:0]  xfer_target = 4'h0;
    logic        bus_sel = 1'b0;
    logic        bus_wr = 1'b0;
    logic        bus_priv = 1'b1;
    logic [3:0]  bus_addr = 4'h0;
    logic [15:0] bus_wdata = 16'h0;
    logic [15:0] bus_rdata;
    logic        irq;

    int compared = 0;
    int mismatched = 0;
    logic [15:0] rv;

    always #2 clk = ~clk;

    mode_irq_regs u_mode_irq_regs (
        .clk(clk), .rst_n(rst_n), .ev_bad_cfg(ev_bad_cfg), .ev_bad_mode(ev_bad_mode),
        .safe_enter(safe_enter), .safe_by_hw(safe_by_hw), .xfer_busy(xfer_busy),
        .xfer_target(xfer_target), .bus_sel(bus_sel), .bus_wr(bus_wr),
        .bus_priv(bus_priv), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .irq(irq)
    );

    task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
        compared++;
        if (act !== exp) begin
            mismatched++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic wr(input logic [3:0] a, input logic [15:0] d, input logic p);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d; bus_priv = p;
        tick();
        bus_sel = 1'b0; bus_wr = 1'b0; bus_priv = 1'b1;
    endtask

    task automatic rd(input logic [3:0] a, input logic p, output logic [15:0] d);
        bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a; bus_priv = p;
        #1;
        d = bus_rdata;
        bus_sel = 1'b0; bus_priv = 1'b1;
    endtask

    task automatic set_all();
        ev_bad_cfg = 1'b1; ev_bad_mode = 1'b1; safe_enter = 1'b1; safe_by_hw = 1'b1;
        xfer_busy = 1'b1; xfer_target = 4'h1;
        tick();
        ev_bad_cfg = 1'b0; ev_bad_mode = 1'b0; safe_enter = 1'b0; safe_by_hw = 1'b0;
        xfer_busy = 1'b0;
        tick();
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        mismatched++;
        compared++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

    initial begin
        repeat (3) tick();
        rst_n = 1'b1;
        // R1 reset state
        rd(4'h0, 1'b1, rv); check("R1 status", rv, 16'h0);
        rd(4'h1, 1'b1, rv); check("R1 mask", rv, 16'h0);
        check("R1 irq", {15'h0, irq}, 16'h0);

        // R2 each source sets its own bit and holds
        for (int i = 0; i < 4; i++) begin
            case (i)
                3: ev_bad_cfg = 1'b1;
                2: ev_bad_mode = 1'b1;
                1: begin safe_enter = 1'b1; safe_by_hw = 1'b1; end
                default: xfer_busy = 1'b1;
            endcase
            tick();
            ev_bad_cfg = 1'b0; ev_bad_mode = 1'b0; safe_enter = 1'b0; safe_by_hw = 1'b0;
            if (i == 0) begin xfer_busy = 1'b0; xfer_target = 4'h2; tick(); end
            repeat (3) tick();
            rd(4'h0, 1'b1, rv); check("R2 sticky bit", rv, 16'(1 << i));
            wr(4'h0, 16'(1 << i), 1'b1);
            rd(4'h0, 1'b1, rv); check("R3 single clear", rv, 16'h0);
        end

        // R3 write-1-clear sweep over all patterns
        for (int p = 0; p < 16; p++) begin
            set_all();
            wr(4'h0, 16'hA5A0 | 16'(p), 1'b1);
            rd(4'h0, 1'b1, rv); check("R3 w1c sweep", rv, 16'(4'hF & ~4'(p)));
        end

        // R7 mask write/readback, upper bits dropped, unmapped reads zero
        for (int m = 0; m < 16; m++) begin
            wr(4'h1, 16'hFFF0 | 16'(m), 1'b1);
            rd(4'h1, 1'b1, rv); check("R7 mask readback", rv, 16'(m));
        end
        rd(4'h5, 1'b1, rv); check("R7 unmapped read", rv, 16'h0);

        // R8 all status/mask combinations
        for (int s = 0; s < 16; s++) begin
            for (int m = 0; m < 16; m++) begin
                set_all();
                wr(4'h0, 16'(4'hF & ~4'(s)), 1'b1);
                wr(4'h1, 16'(m), 1'b1);
                tick();
                check("R8 irq combo", {15'h0, irq}, {15'h0, ((s & m) != 0)});
            end
        end

        // R8 latency: flag then irq one cycle later
        wr(4'h1, 16'hF, 1'b1);
        wr(4'h0, 16'hF, 1'b1);
        tick();
        ev_bad_mode = 1'b1;
        tick();
        ev_bad_mode = 1'b0;
        check("R8 irq not yet", {15'h0, irq}, 16'h0);
        tick();
        check("R8 irq one later", {15'h0, irq}, 16'h1);

        // R4/R5 every target code through a falling busy edge
        for (int t = 0; t < 16; t++) begin
            wr(4'h0, 16'hF, 1'b1);
            xfer_busy = 1'b1; xfer_target = 4'(t);
            tick();
            xfer_busy = 1'b0;
            tick();
            rd(4'h0, 1'b1, rv);
            check("R5 target sweep", rv, (t == 8 || t == 10) ? 16'h0 : 16'h1);
        end

        // R5 qualifier taken in the falling cycle only
        wr(4'h0, 16'hF, 1'b1);
        xfer_busy = 1'b1; xfer_target = 4'd8; tick();
        xfer_busy = 1'b0; xfer_target = 4'd3; tick();
        rd(4'h0, 1'b1, rv); check("R5 target at fall (3)", rv, 16'h1);
        wr(4'h0, 16'hF, 1'b1);
        xfer_busy = 1'b1; xfer_target = 4'd3; tick();
        xfer_busy = 1'b0; xfer_target = 4'd10; tick();
        rd(4'h0, 1'b1, rv); check("R5 target at fall (10)", rv, 16'h0);

        // R4 rising and held busy do not set
        wr(4'h0, 16'hF, 1'b1);
        xfer_target = 4'd2; xfer_busy = 1'b1;
        repeat (4) tick();
        rd(4'h0, 1'b1, rv); check("R4 busy held", rv, 16'h0);
        xfer_busy = 1'b0; tick();
        rd(4'h0, 1'b1, rv); check("R4 busy fell", rv, 16'h1);

        // R6 safe flag only on hardware-caused entry
        wr(4'h0, 16'hF, 1'b1);
        safe_enter = 1'b1; safe_by_hw = 1'b0; tick();
        rd(4'h0, 1'b1, rv); check("R6 software safe", rv, 16'h0);
        safe_enter = 1'b0; safe_by_hw = 1'b1; tick();
        rd(4'h0, 1'b1, rv); check("R6 cause without entry", rv, 16'h0);
        safe_enter = 1'b1; tick();
        safe_enter = 1'b0; safe_by_hw = 1'b0;
        rd(4'h0, 1'b1, rv); check("R6 hardware safe", rv, 16'h2);

        // R9 user writes ignored, user reads work
        wr(4'h1, 16'h0, 1'b1);
        wr(4'h1, 16'hF, 1'b0);
        rd(4'h1, 1'b0, rv); check("R9 user mask write", rv, 16'h0);
        set_all();
        wr(4'h0, 16'hF, 1'b0);
        rd(4'h0, 1'b0, rv); check("R9 user status clear", rv, 16'hF);

        // R10 set beats same-cycle clear
        ev_bad_cfg = 1'b1;
        wr(4'h0, 16'hF, 1'b1);
        ev_bad_cfg = 1'b0;
        rd(4'h0, 1'b1, rv); check("R10 cfg set vs clear", rv, 16'h8);
        wr(4'h0, 16'hF, 1'b1);
        xfer_target = 4'd0; xfer_busy = 1'b1; tick();
        xfer_busy = 1'b0;
        wr(4'h0, 16'h1, 1'b1);
        rd(4'h0, 1'b1, rv); check("R10 done set vs clear", rv, 16'h1);

        // R1 reset mid-run clears everything
        wr(4'h1, 16'hF, 1'b1);
        rst_n = 1'b0; tick(); rst_n = 1'b1;
        rd(4'h0, 1'b1, rv); check("R1 rerun status", rv, 16'h0);
        rd(4'h1, 1'b1, rv); check("R1 rerun mask", rv, 16'h0);
        check("R1 rerun irq", {15'h0, irq}, 16'h0);

        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end
endmodule